// File: doc/BRIEF.md
# SCSI Message-In Frame Assembler

This block sits behind the initiator's receive path during the message-in phase. It takes one byte at a time, qualified by a valid strobe. It keeps the bytes of the current message in a small buffer and uses the first byte to work out when the message is complete. A one-byte code ends the frame at once. A two-byte code ends it at the second byte. An extended message ends when the buffer holds its length byte plus two header bytes.

When a frame ends, the block classifies it and issues one action for a single cycle. The possible actions are:
- release the bus on command complete;
- acknowledge a reject;
- no operation;
- accept a synchronous transfer agreement, with its period and offset;
- ask for a counter-proposal at the fastest allowed period;
- reply with a reject.

The block also keeps two persistent flags, one for "agreement reached" and one for "synchronous mode in use". The sequencer can use these flags together with the action's period and offset to program the bus timing. A clear input discards a partly assembled frame.

Top module: `mi_frame_asm`

## Requirements
- R1: After reset, act_valid, frame_cnt, sync_negotiated and sync_mode are all 0.
- R2: Some first bytes complete the frame on their own: 0x00, 0x02 to 0x1F, and 0x80 to 0xFF. For these, act_valid is high in the cycle after the byte is taken, and frame_cnt is 0 in that same cycle.
- R3: A first byte in 0x20 to 0x2F completes the frame on the second byte. No two-byte code is supported, so the action is send-reject (code 5).
- R4: A first byte of 0x01 starts an extended frame. It completes on the byte that makes the count equal to byte[1] + 2, which can be no earlier than the third byte. A frame of 16 bytes (byte[1] = 14) completes normally.
- R5: A frame 0x00 yields action bus-free (code 0).
- R6: A frame 0x07 yields reject-acknowledged (code 1) with period 0 and offset 0. If sync_pending was high when the byte was taken, sync_mode is cleared. Otherwise sync_mode is unchanged.
- R7: A frame 0x08 yields no-op (code 2).
- R8: A frame 0x01, 0x03, 0x01, P, O with P >= 25 yields sync-accept (code 3) with act_period = P and act_offset = O. It also sets both sync_negotiated and sync_mode.
- R9: The same frame with P < 25 yields counter-proposal (code 4) with period 25 and offset 15, and leaves both flags unchanged.
- R10: Any other frame yields send-reject (code 5). This covers other one-byte codes and extended frames whose code byte (byte[2]) is not 0x01 or whose length byte is not 3.
- R11: If the 16th byte does not complete a frame, the block yields send-reject and frame_cnt returns to 0.
- R12: clr has priority over in_valid. It sets frame_cnt to 0 without any action, and the next byte is treated as a first byte.
- R13: act_valid is high only in the cycle after a completing byte. Outside sync-accept and counter-proposal, act_period and act_offset are 0 whenever act_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Discard the frame being assembled |
| in_valid | input | 1 | in_byte holds a received message byte this cycle |
| in_byte | input | 8 | Received message byte |
| sync_pending | input | 1 | A synchronous transfer request of ours is outstanding |
| act_valid | output | 1 | One-cycle strobe: action fields are valid |
| act_code | output | 3 | 0 bus-free, 1 reject-ack, 2 no-op, 3 sync-accept, 4 counter-proposal, 5 send-reject |
| act_period | output | 8 | Transfer period attached to the action |
| act_offset | output | 8 | Transfer offset attached to the action |
| sync_negotiated | output | 1 | A synchronous agreement has been reached |
| sync_mode | output | 1 | Synchronous transfers are in use |
| frame_cnt | output | CW | Bytes held of the current frame |

## Verification
The checks assume in_valid and clr are driven from the same clock domain. They also assume sync_pending is steady while the byte that completes a frame is being taken, because the reject-acknowledge rule samples it at that byte. The stimulus changes inputs a short time after each rising edge and sets sync_pending once before the first byte of each frame. It builds every random frame to its complete length, so no frame is left half-open, except for the directed clear and overflow cases.

// File: rtl/mi_pkg.sv
package mi_pkg;

    typedef enum logic [2:0] {
        ACT_BUSFREE  = 3'd0,
        ACT_REJ_ACK  = 3'd1,
        ACT_NOP      = 3'd2,
        ACT_SYNC_OK  = 3'd3,
        ACT_COUNTER  = 3'd4,
        ACT_SEND_REJ = 3'd5
    } act_e;

    typedef enum logic [1:0] {
        CLS_ONE = 2'd0,
        CLS_TWO = 2'd1,
        CLS_EXT = 2'd2
    } cls_e;

    localparam logic [7:0] MC_DONE   = 8'h00;
    localparam logic [7:0] MC_EXT    = 8'h01;
    localparam logic [7:0] MC_REJECT = 8'h07;
    localparam logic [7:0] MC_NOP    = 8'h08;
    localparam logic [7:0] XC_SYNC   = 8'h01;
    localparam logic [7:0] XL_SYNC   = 8'h03;
    localparam logic [7:0] TWO_LO    = 8'h20;
    localparam logic [7:0] TWO_HI    = 8'h2F;

endpackage

// File: rtl/mi_class.sv
module mi_class
    import mi_pkg::*;
(
    input  logic [7:0] first_byte,
    output cls_e       cls
);
    always_comb begin
        if (first_byte == MC_EXT) begin
            cls = CLS_EXT;
        end else if (first_byte >= TWO_LO && first_byte <= TWO_HI) begin
            cls = CLS_TWO;
        end else begin
            cls = CLS_ONE;
        end
    end
endmodule

// File: rtl/mi_frame_end.sv
module mi_frame_end
    import mi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  cls_e          cls,
    input  logic [CW-1:0] n_next,
    input  logic [7:0]    len_byte,
    output logic          done,
    output logic          overflow
);
    int n_i;
    int want_i;

    always_comb begin
        n_i    = int'(n_next);
        want_i = int'(len_byte) + 2;
        unique case (cls)
            CLS_ONE: done = (n_i == 1);
            CLS_TWO: done = (n_i == 2);
            CLS_EXT: done = (n_i >= 3) && (n_i == want_i);
            default: done = 1'b0;
        endcase
        overflow = !done && (n_i == DEPTH);
    end
endmodule

// File: rtl/mi_decode.sv
module mi_decode
    import mi_pkg::*;
#(
    parameter int MIN_PERIOD = 25,
    parameter int MAX_OFFSET = 15
) (
    input  logic [7:0] b0,
    input  logic [7:0] b1,
    input  logic [7:0] b2,
    input  logic [7:0] b3,
    input  logic [7:0] b4,
    input  logic       overflow,
    input  logic       sync_pending,
    output act_e       act,
    output logic [7:0] period,
    output logic [7:0] offset,
    output logic       set_sync,
    output logic       drop_sync
);
    localparam logic [7:0] MINP = 8'(MIN_PERIOD);
    localparam logic [7:0] MAXO = 8'(MAX_OFFSET);

    logic is_sync_req;

    always_comb begin
        is_sync_req = (b0 == MC_EXT) && (b1 == XL_SYNC) && (b2 == XC_SYNC);
        act       = ACT_SEND_REJ;
        period    = 8'd0;
        offset    = 8'd0;
        set_sync  = 1'b0;
        drop_sync = 1'b0;
        if (!overflow) begin
            if (b0 == MC_DONE) begin
                act = ACT_BUSFREE;
            end else if (b0 == MC_REJECT) begin
                act       = ACT_REJ_ACK;
                drop_sync = sync_pending;
            end else if (b0 == MC_NOP) begin
                act = ACT_NOP;
            end else if (is_sync_req) begin
                if (b3 < MINP) begin
                    act    = ACT_COUNTER;
                    period = MINP;
                    offset = MAXO;
                end else begin
                    act      = ACT_SYNC_OK;
                    period   = b3;
                    offset   = b4;
                    set_sync = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mi_frame_asm.sv
module mi_frame_asm
    import mi_pkg::*;
#(
    parameter  int DEPTH      = 16,
    parameter  int MIN_PERIOD = 25,
    parameter  int MAX_OFFSET = 15,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          sync_pending,
    output logic          act_valid,
    output logic [2:0]    act_code,
    output logic [7:0]    act_period,
    output logic [7:0]    act_offset,
    output logic          sync_negotiated,
    output logic          sync_mode,
    output logic [CW-1:0] frame_cnt
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [CW-1:0]         cnt;
        logic                  av;
        act_e                  act;
        logic [7:0]            per;
        logic [7:0]            off;
        logic                  neg;
        logic                  smode;
    } state_t;

    state_t st_d, st_q;

    logic [7:0]    view_d [DEPTH];
    logic [CW-1:0] n_next_d;
    cls_e          cls_d;
    logic          done_d, ovf_d;
    act_e          dec_act_d;
    logic [7:0]    dec_per_d, dec_off_d;
    logic          set_sync_d, drop_sync_d;

    // Buffer contents as they will be once the incoming byte is stored.
    for (genvar k = 0; k < DEPTH; k++) begin : g_view
        assign view_d[k] = (in_valid && (st_q.cnt == CW'(k))) ? in_byte : st_q.mem[k];
    end

    assign n_next_d = st_q.cnt + CW'(1);

    mi_class u_class (
        .first_byte (view_d[0]),
        .cls        (cls_d)
    );

    mi_frame_end #(.DEPTH(DEPTH), .CW(CW)) u_end (
        .cls      (cls_d),
        .n_next   (n_next_d),
        .len_byte (view_d[1]),
        .done     (done_d),
        .overflow (ovf_d)
    );

    mi_decode #(.MIN_PERIOD(MIN_PERIOD), .MAX_OFFSET(MAX_OFFSET)) u_dec (
        .b0           (view_d[0]),
        .b1           (view_d[1]),
        .b2           (view_d[2]),
        .b3           (view_d[3]),
        .b4           (view_d[4]),
        .overflow     (ovf_d),
        .sync_pending (sync_pending),
        .act          (dec_act_d),
        .period       (dec_per_d),
        .offset       (dec_off_d),
        .set_sync     (set_sync_d),
        .drop_sync    (drop_sync_d)
    );

    always_comb begin
        st_d    = st_q;
        st_d.av = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (in_valid) begin
            for (int k = 0; k < DEPTH; k++) begin
                st_d.mem[k] = view_d[k];
            end
            if (done_d || ovf_d) begin
                st_d.cnt = '0;
                st_d.av  = 1'b1;
                st_d.act = dec_act_d;
                st_d.per = dec_per_d;
                st_d.off = dec_off_d;
                if (set_sync_d) begin
                    st_d.neg   = 1'b1;
                    st_d.smode = 1'b1;
                end
                if (drop_sync_d) begin
                    st_d.smode = 1'b0;
                end
            end else begin
                st_d.cnt = n_next_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_valid       = st_q.av;
    assign act_code        = st_q.act;
    assign act_period      = st_q.per;
    assign act_offset      = st_q.off;
    assign sync_negotiated = st_q.neg;
    assign sync_mode       = st_q.smode;
    assign frame_cnt       = st_q.cnt;

endmodule

// File: rtl/mi_frame_asm_chk.sv
module mi_frame_asm_chk #(
    parameter int DEPTH      = 16,
    parameter int MIN_PERIOD = 25,
    parameter int MAX_OFFSET = 15,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          in_valid,
    input logic          sync_pending,
    input logic          act_valid,
    input logic [2:0]    act_code,
    input logic [7:0]    act_period,
    input logic [7:0]    act_offset,
    input logic          sync_negotiated,
    input logic          sync_mode,
    input logic [CW-1:0] frame_cnt
);
    a_r13_cause: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ($past(in_valid) && !$past(clr)));

    a_r2_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (frame_cnt == '0));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_cnt) < DEPTH);

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (frame_cnt == '0 && !act_valid));

    a_r9_counter: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 3'd4) |->
            (act_period == 8'(MIN_PERIOD) && act_offset == 8'(MAX_OFFSET)));

    a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 3'd3) |-> (sync_negotiated && sync_mode));

    a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 3'd3) |-> (act_period >= 8'(MIN_PERIOD)));

    a_r6_async: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 3'd1 && $past(sync_pending)) |-> !sync_mode);

    a_r13_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code != 3'd3 && act_code != 3'd4) |->
            (act_period == 8'd0 && act_offset == 8'd0));

    a_r13_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_code <= 3'd5));
endmodule

bind mi_frame_asm mi_frame_asm_chk #(
    .DEPTH(DEPTH), .MIN_PERIOD(MIN_PERIOD), .MAX_OFFSET(MAX_OFFSET), .CW(CW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .sync_pending(sync_pending), .act_valid(act_valid), .act_code(act_code),
    .act_period(act_period), .act_offset(act_offset),
    .sync_negotiated(sync_negotiated), .sync_mode(sync_mode),
    .frame_cnt(frame_cnt)
);

// File: tb/mi_frame_asm_tb_top.sv
module mi_frame_asm_tb_top;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 16;
    localparam int CW     = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h0;
    logic          sync_pending = 1'b0;
    logic          act_valid;
    logic [2:0]    act_code;
    logic [7:0]    act_period, act_offset;
    logic          sync_negotiated, sync_mode;
    logic [CW-1:0] frame_cnt;

    int tests = 0;
    int fails = 0;
    bit m_neg = 1'b0;
    bit m_smode = 1'b0;
    logic [7:0] fr [DEPTH];

    always #(CLK_NS/2) clk = ~clk;

    mi_frame_asm dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_byte(in_byte), .sync_pending(sync_pending),
        .act_valid(act_valid), .act_code(act_code), .act_period(act_period),
        .act_offset(act_offset), .sync_negotiated(sync_negotiated),
        .sync_mode(sync_mode), .frame_cnt(frame_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Frame length rule from the requirements (R2, R3, R4).
    function automatic bit frame_done(input logic [7:0] b0, input logic [7:0] b1, input int n);
        if (b0 == 8'h01) return (n >= 3) && (n == int'(b1) + 2);
        if (b0 >= 8'h20 && b0 <= 8'h2F) return n == 2;
        return n == 1;
    endfunction

    // Expected action code (R5..R11).
    function automatic int exp_code(input bit ovf);
        if (ovf) return 5;
        if (fr[0] == 8'h00) return 0;
        if (fr[0] == 8'h07) return 1;
        if (fr[0] == 8'h08) return 2;
        if (fr[0] == 8'h01 && fr[1] == 8'h03 && fr[2] == 8'h01)
            return (fr[3] < 8'd25) ? 4 : 3;
        return 5;
    endfunction

    task automatic push(input logic [7:0] b);
        in_byte  = b;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input int len, input bit pend, input string req);
        sync_pending = pend;
        for (int k = 0; k < len; k++) begin
            push(fr[k]);
            begin
                bit done, ovf;
                int ec, ep, eo;
                done = frame_done(fr[0], fr[1], k + 1);
                ovf  = !done && (k + 1 == DEPTH);
                if (done || ovf) begin
                    ec = exp_code(ovf);
                    ep = 0; eo = 0;
                    if (ec == 3) begin ep = fr[3]; eo = fr[4]; m_neg = 1; m_smode = 1; end
                    if (ec == 4) begin ep = 25; eo = 15; end
                    if (ec == 1 && pend) m_smode = 0;
                    chk(act_valid == 1'b1, req, "act_valid at end", act_valid, 1);
                    chk(int'(act_code) == ec, req, "act_code", act_code, ec);
                    chk(int'(act_period) == ep, req, "act_period", act_period, ep);
                    chk(int'(act_offset) == eo, req, "act_offset", act_offset, eo);
                    chk(frame_cnt == '0, req, "frame_cnt after end (R2)", frame_cnt, 0);
                    chk(sync_negotiated == m_neg, req, "sync_negotiated", sync_negotiated, m_neg);
                    chk(sync_mode == m_smode, req, "sync_mode", sync_mode, m_smode);
                    break;
                end else begin
                    chk(act_valid == 1'b0, req, "act_valid mid-frame (R13)", act_valid, 0);
                    chk(int'(frame_cnt) == k + 1, req, "frame_cnt mid-frame", frame_cnt, k + 1);
                end
            end
        end
    endtask

    task automatic idle_check();
        @(posedge clk);
        #1;
        chk(act_valid == 1'b0, "R13", "act_valid when idle", act_valid, 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL R13 watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(act_valid == 1'b0, "R1", "act_valid reset", act_valid, 0);
        chk(frame_cnt == '0, "R1", "frame_cnt reset", frame_cnt, 0);
        chk(sync_negotiated == 1'b0, "R1", "negotiated reset", sync_negotiated, 0);
        chk(sync_mode == 1'b0, "R1", "sync_mode reset", sync_mode, 0);

        fr[0] = 8'h00; send_frame(1, 0, "R5");
        idle_check();
        fr[0] = 8'h08; send_frame(1, 0, "R7");
        fr[0] = 8'h07; send_frame(1, 0, "R6");
        fr[0] = 8'h23; fr[1] = 8'h05; send_frame(2, 0, "R3");
        fr[0] = 8'h01; fr[1] = 8'h03; fr[2] = 8'h01; fr[3] = 8'd12; fr[4] = 8'd7;
        send_frame(5, 1, "R9");
        fr[3] = 8'd24; send_frame(5, 1, "R9");
        fr[3] = 8'd25; fr[4] = 8'd8; send_frame(5, 1, "R8");
        fr[3] = 8'd50; fr[4] = 8'd3; send_frame(5, 0, "R8");
        fr[0] = 8'h07; send_frame(1, 0, "R6");
        fr[0] = 8'h07; send_frame(1, 1, "R6");
        fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'h02; fr[3] = 8'h11;
        send_frame(4, 0, "R10");
        fr[0] = 8'h01; fr[1] = 8'h01; fr[2] = 8'h01; send_frame(3, 0, "R4");
        fr[0] = 8'h05; send_frame(1, 0, "R10");
        fr[0] = 8'h85; send_frame(1, 0, "R10");
        fr[0] = 8'h01; fr[1] = 8'h20;
        for (int k = 2; k < DEPTH; k++) fr[k] = 8'(k);
        send_frame(DEPTH, 0, "R11");
        fr[0] = 8'h01; fr[1] = 8'd14; fr[2] = 8'h09;
        send_frame(DEPTH, 0, "R4");

        push(8'h01); push(8'h03); push(8'h01);
        clr = 1'b1; in_valid = 1'b1; in_byte = 8'h00;
        @(posedge clk); #1;
        clr = 1'b0; in_valid = 1'b0;
        chk(frame_cnt == '0, "R12", "frame_cnt after clr", frame_cnt, 0);
        chk(act_valid == 1'b0, "R12", "act_valid after clr", act_valid, 0);
        fr[0] = 8'h08; send_frame(1, 0, "R12");

        for (int i = 0; i < 400; i++) begin
            int kind, len;
            bit pend;
            kind = $urandom % 6;
            pend = 1'($urandom % 2);
            for (int k = 0; k < DEPTH; k++) fr[k] = 8'($urandom);
            case (kind)
                0: begin
                    if (fr[0] == 8'h01 || (fr[0] >= 8'h20 && fr[0] <= 8'h2F)) fr[0] = 8'h08;
                    len = 1;
                end
                1: begin fr[0] = 8'h20 + 8'($urandom % 16); len = 2; end
                2: begin
                    fr[0] = 8'h01; fr[1] = 8'h03; fr[2] = 8'h01;
                    fr[3] = 8'($urandom % 60); fr[4] = 8'($urandom % 16); len = 5;
                end
                3: begin
                    fr[0] = 8'h01; fr[1] = 8'(1 + $urandom % 13); len = int'(fr[1]) + 2;
                end
                4: begin
                    case ($urandom % 3)
                        0: fr[0] = 8'h00;
                        1: fr[0] = 8'h07;
                        default: fr[0] = 8'h08;
                    endcase
                    len = 1;
                end
                default: begin
                    fr[0] = 8'h01; fr[1] = 8'(1 + $urandom % 5); fr[2] = 8'h01;
                    len = int'(fr[1]) + 2;
                end
            endcase
            send_frame(len, pend, "R2/R10 random");
        end
        idle_check();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule